// File: doc/BRIEF.md
# Buck Converter Fault and Power-Good Supervisor

This block is the digital sequencing core of a synchronous buck controller. The analog front end reduces the output and switch-node measurements to single-bit comparator flags. The supervisor takes those flags, together with a power-on-reset status, a soft-start completion flag and the two gate requests from the PWM modulator. From them it produces the final high-side and low-side gate enables, a power-good indication and a two-bit code for the latched fault.

Each fault class ends in its own gate state. An under-voltage or over-current fault turns both switches off. An over-voltage fault holds the low-side switch on so that the output discharges. Once the output has fallen below its low threshold, both switches go off. The protection checks arm at different phases. The over-voltage check runs as soon as the bias supply is good. The under-voltage check waits for soft-start to finish. The over-current check uses only the samples taken while the low-side switch conducts. Only a fresh power-on reset releases a latched fault. The disable input stops switching but leaves the latch in place.

Top module: `buck_supervisor`

## Requirements
- R1: While `por_ok` is low, `hs_en`, `ls_en` and `pwr_good` are 0. When `por_ok` is sampled low at a clock edge, the latched fault code returns to 00 and the over-current period count clears. No other input clears a latched fault.
- R2: With `por_ok` high, `dis_req` low and no fault latched, `hs_en` = `pwm_hi` AND NOT `pwm_lo`, and `ls_en` = `pwm_lo` AND NOT `pwm_hi`. When both requests are high, both enables are 0. These outputs are combinational and take effect in the same cycle.
- R3: While `dis_req` is high, both gate enables and `pwr_good` are 0, unless an over-voltage clamp is active. When `dis_req` is released, switching resumes. Toggling `dis_req` does not change a latched fault code.
- R4: An under-voltage flag is acted on only while `ss_done` is high. It latches code 01 at the next clock edge, and from then on both gate enables stay 0.
- R5: An over-voltage flag is acted on whenever `por_ok` is high, including before soft-start completes and while disabled. It latches code 11 at the next clock edge. In that state `hs_en` is 0 and `ls_en` is 1, regardless of the gate requests or `dis_req`.
- R6: During the over-voltage clamp, a sampled `low04_flag` ends the clamp. From the following cycle both enables are 0, and they stay 0 until a power-on reset. The code stays 11.
- R7: A low-side period is a run of consecutive cycles with `ls_en` high. A period counts as flagged if `oc_flag` is high in any of its cycles. The count advances in the first cycle after the period ends. A clean period resets the count to zero. `oc_flag` outside a low-side period has no effect. When two consecutive periods are flagged, code 10 latches at the clock edge that closes the cycle after the second flagged period, and both enables are then 0.
- R8: When several fault conditions are present in the same cycle, the priority is over-voltage, then over-current, then under-voltage. Once a code is latched, later fault flags change neither the code nor the gate state.
- R9: `pwr_good` = `por_ok` AND `ss_done` AND `win_ok` AND NOT `dis_req` AND (code = 00), evaluated combinationally. A low `win_ok` lowers only `pwr_good`; the gates keep following the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_ok | input | 1 | Bias supply power-on reset good |
| dis_req | input | 1 | Disable request (enable pin below its threshold) |
| ss_done | input | 1 | Soft-start ramp has completed |
| pwm_hi | input | 1 | High-side gate request from the modulator |
| pwm_lo | input | 1 | Low-side gate request from the modulator |
| uv_flag | input | 1 | Output below under-voltage threshold |
| ov_flag | input | 1 | Output above over-voltage threshold |
| low04_flag | input | 1 | Output below the 0.4 V discharge threshold |
| oc_flag | input | 1 | Switch-node sense exceeds the current limit |
| win_ok | input | 1 | Output inside the power-good window |
| hs_en | output | 1 | Final high-side gate enable |
| ls_en | output | 1 | Final low-side gate enable |
| pwr_good | output | 1 | Power-good indication |
| fault_code | output | 2 | Latched fault: 00 none, 01 under-voltage, 10 over-current, 11 over-voltage |

## Verification
A wrong internal state shows on `fault_code` in the first cycle after the clock edge that took it. In that same cycle the gate enables take on the state tied to that code, so a mis-latched fault shows up as a lost or forced gate before any further edge. A lost or extra over-current count stays hidden until the end of the next low-side period. The trip then appears one period early or late, so the bench arranges flagged and clean periods in sequence, exposing an off-by-one count within three periods. Priority and latch-hold errors appear as a wrong code on the edge following simultaneous or later flags.

// File: rtl/bsv_pkg.sv
package bsv_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_UV_OFF   = 3'd1,
    ST_OC_OFF   = 3'd2,
    ST_OV_CLAMP = 3'd3,
    ST_OV_OFF   = 3'd4
  } sup_state_t;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_UV   = 2'b01,
    FC_OC   = 2'b10,
    FC_OV   = 2'b11
  } fault_code_t;

endpackage

// File: rtl/bsv_oc_filter.sv
module bsv_oc_filter #(
  parameter int OC_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ls_on,
  input  logic oc_flag,
  output logic trip
);

  localparam int CNT_W = (OC_PERIODS < 2) ? 1 : $clog2(OC_PERIODS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OC_PERIODS - 1);

  logic             ls_prev_q, ls_prev_d;
  logic             hit_q, hit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             period_end;

  // next-state logic
  always_comb begin
    period_end = ls_prev_q & ~ls_on;
    ls_prev_d  = ls_on;
    hit_d      = hit_q | (ls_on & oc_flag);
    cnt_d      = cnt_q;
    trip       = 1'b0;
    if (period_end) begin
      hit_d = 1'b0;
      if (hit_q) begin
        if (cnt_q == LAST) trip = 1'b1;
        else               cnt_d = cnt_q + CNT_W'(1);
      end else begin
        cnt_d = '0;
      end
    end
    if (clr) begin
      ls_prev_d = 1'b0;
      hit_d     = 1'b0;
      cnt_d     = '0;
      trip      = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_prev_q <= 1'b0;
      hit_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      ls_prev_q <= ls_prev_d;
      hit_q     <= hit_d;
      cnt_q     <= cnt_d;
    end
  end

  // R7: a trip is only raised once the low side has stopped conducting
  a_r7_trip_after_ls: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> !ls_on);

  // R7: a trip needs the low side to have been on at the previous edge
  a_r7_trip_needs_period: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> $past(ls_on));

endmodule

// File: rtl/bsv_fault_fsm.sv
module bsv_fault_fsm
  import bsv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_ok,
  input  logic        ss_done,
  input  logic        uv_flag,
  input  logic        ov_flag,
  input  logic        low04_flag,
  input  logic        oc_trip,
  output sup_state_t  state_o,
  output fault_code_t code_o
);

  sup_state_t state_q, state_d;

  // next-state logic: first fault wins, priority OV > OC > UV
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (ov_flag)                state_d = ST_OV_CLAMP;
        else if (oc_trip)           state_d = ST_OC_OFF;
        else if (ss_done && uv_flag) state_d = ST_UV_OFF;
      end
      ST_OV_CLAMP: if (low04_flag) state_d = ST_OV_OFF;
      default:     state_d = state_q;
    endcase
    if (!por_ok) state_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_UV_OFF:              code_o = FC_UV;
      ST_OC_OFF:              code_o = FC_OC;
      ST_OV_CLAMP, ST_OV_OFF: code_o = FC_OV;
      default:                code_o = FC_NONE;
    endcase
  end

  assign state_o = state_q;

  // R8: a latched code holds while the supply stays good
  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != FC_NONE && por_ok) |=> code_o == $past(code_o));

  // R4: under-voltage is ignored before soft-start completes
  a_r4_uv_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == FC_NONE && uv_flag && !ss_done && !ov_flag && !oc_trip) |=> code_o == FC_NONE);

  // R1: power-on reset clears the latch
  a_r1_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> code_o == FC_NONE);

endmodule

// File: rtl/bsv_gate_ctl.sv
module bsv_gate_ctl
  import bsv_pkg::*;
(
  input  logic       por_ok,
  input  logic       dis_req,
  input  sup_state_t state,
  input  logic       pwm_hi,
  input  logic       pwm_lo,
  output logic       hs_en,
  output logic       ls_en
);

  logic run_ok;
  logic clamp;

  always_comb begin
    run_ok = por_ok & ~dis_req & (state == ST_RUN);
    clamp  = por_ok & (state == ST_OV_CLAMP);
    hs_en  = run_ok & pwm_hi & ~pwm_lo;
    ls_en  = (run_ok & pwm_lo & ~pwm_hi) | clamp;
  end

  // R2: the two switches are never enabled together
  always_comb begin
    a_r2_no_overlap: assert (!(hs_en && ls_en));
  end

endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
  import bsv_pkg::*;
#(
  parameter int OC_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       dis_req,
  input  logic       ss_done,
  input  logic       pwm_hi,
  input  logic       pwm_lo,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       low04_flag,
  input  logic       oc_flag,
  input  logic       win_ok,
  output logic       hs_en,
  output logic       ls_en,
  output logic       pwr_good,
  output logic [1:0] fault_code
);

  sup_state_t  state_w;
  fault_code_t code_w;
  logic        oc_trip_w;

  bsv_oc_filter #(.OC_PERIODS(OC_PERIODS)) oc_filt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~por_ok),
    .ls_on   (ls_en),
    .oc_flag (oc_flag),
    .trip    (oc_trip_w)
  );

  bsv_fault_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_ok     (por_ok),
    .ss_done    (ss_done),
    .uv_flag    (uv_flag),
    .ov_flag    (ov_flag),
    .low04_flag (low04_flag),
    .oc_trip    (oc_trip_w),
    .state_o    (state_w),
    .code_o     (code_w)
  );

  bsv_gate_ctl gate_i (
    .por_ok  (por_ok),
    .dis_req (dis_req),
    .state   (state_w),
    .pwm_hi  (pwm_hi),
    .pwm_lo  (pwm_lo),
    .hs_en   (hs_en),
    .ls_en   (ls_en)
  );

  assign fault_code = code_w;
  assign pwr_good   = por_ok & ss_done & win_ok & ~dis_req & (code_w == FC_NONE);

  // R4: under-voltage and over-current latches keep both switches off
  a_r4_off_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == FC_UV || fault_code == FC_OC) |-> (!hs_en && !ls_en));

  // R5: an over-voltage latch never lets the high side on
  a_r5_ov_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code == FC_OV |-> !hs_en);

  // R6: after the discharge threshold is seen, the low side stays off
  a_r6_clamp_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_code) == FC_OV && $past(low04_flag) && fault_code == FC_OV) |-> !ls_en);

  // R5: a fresh over-voltage flag in a clean state forces the low side on next
  a_r5_ov_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && fault_code == FC_NONE && ov_flag) |=> (!por_ok || ls_en || $past(low04_flag) || low04_flag || fault_code == FC_OV));

endmodule

// File: tb/buck_supervisor_tb.sv
`timescale 1ns/1ps
module buck_supervisor_tb_top;

  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n, por_ok, dis_req, ss_done, pwm_hi, pwm_lo;
  logic uv_flag, ov_flag, low04_flag, oc_flag, win_ok;
  logic hs_en, ls_en, pwr_good;
  logic [1:0] fault_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(HALF) clk = ~clk;

  buck_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .dis_req(dis_req),
    .ss_done(ss_done), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .low04_flag(low04_flag),
    .oc_flag(oc_flag), .win_ok(win_ok),
    .hs_en(hs_en), .ls_en(ls_en), .pwr_good(pwr_good), .fault_code(fault_code)
  );

  // {dis, ss, win, hi, lo, uv, exp_hs, exp_ls, exp_pg}
  localparam logic [8:0] VEC [8] = '{
    9'b001100_100,
    9'b001011_010,
    9'b011100_101,
    9'b010010_010,
    9'b011110_001,
    9'b111100_000,
    9'b101011_000,
    9'b011000_001
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic por_cycle();
    por_ok = 1'b0;
    #0.5;
    chk("R1 gates off while por low", {hs_en, ls_en, pwr_good}, 0);
    step();
    chk("R1 por clears code", fault_code, 0);
    por_ok = 1'b1;
  endtask

  task automatic lo_period(input logic f);
    pwm_hi = 1'b0; pwm_lo = 1'b1; oc_flag = f;
    step();
    step();
    pwm_lo = 1'b0; pwm_hi = 1'b1; oc_flag = 1'b0;
    step();
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_ok = 1'b0; dis_req = 1'b0; ss_done = 1'b0;
    pwm_hi = 1'b1; pwm_lo = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;
    low04_flag = 1'b0; oc_flag = 1'b0; win_ok = 1'b1;
    step(); step(); step();
    chk("R1 reset gates", {hs_en, ls_en}, 0);
    chk("R1 reset pg", pwr_good, 0);
    chk("R1 reset code", fault_code, 0);
    rst_n = 1'b1;
    step();
    chk("R1 por low keeps hs off", hs_en, 0);
    por_ok = 1'b1;
    #0.5;
    chk("R2 hs follows request", hs_en, 1);

    // table walk: normal gating, disable, window, unarmed UV
    foreach (VEC[i]) begin
      dis_req = VEC[i][8]; ss_done = VEC[i][7]; win_ok = VEC[i][6];
      pwm_hi  = VEC[i][5]; pwm_lo  = VEC[i][4]; uv_flag = VEC[i][3];
      #0.5;
      chk($sformatf("R2/R3/R9 vector %0d gates", i), {hs_en, ls_en}, VEC[i][2:1]);
      chk($sformatf("R9 vector %0d pg", i), pwr_good, VEC[i][0]);
      step();
      chk($sformatf("R4 vector %0d no fault", i), fault_code, 0);
    end
    uv_flag = 1'b0; dis_req = 1'b0;

    // R4 under-voltage latch
    ss_done = 1'b1; win_ok = 1'b1; pwm_hi = 1'b1; pwm_lo = 1'b0; uv_flag = 1'b1;
    step();
    uv_flag = 1'b0;
    chk("R4 uv code", fault_code, 1);
    chk("R4 uv gates off", {hs_en, ls_en}, 0);
    chk("R9 pg low on fault", pwr_good, 0);
    ov_flag = 1'b1;
    step();
    ov_flag = 1'b0;
    chk("R8 later ov ignored code", fault_code, 1);
    chk("R8 later ov ignored ls", ls_en, 0);
    dis_req = 1'b1; step(); dis_req = 1'b0; step();
    chk("R3 disable keeps latch", fault_code, 1);
    por_cycle();
    #0.5;
    chk("R1 released hs follows", hs_en, 1);

    // R5 over-voltage armed before soft-start and while disabled
    ss_done = 1'b0; dis_req = 1'b1; ov_flag = 1'b1;
    step();
    ov_flag = 1'b0;
    chk("R5 ov code", fault_code, 3);
    chk("R5 ov clamp gates", {hs_en, ls_en}, 2'b01);
    pwm_hi = 1'b0; pwm_lo = 1'b1; dis_req = 1'b0;
    #0.5;
    chk("R5 ls forced on", ls_en, 1);
    low04_flag = 1'b1;
    step();
    low04_flag = 1'b0;
    chk("R6 clamp released gates", {hs_en, ls_en}, 0);
    chk("R6 code stays ov", fault_code, 3);
    pwm_hi = 1'b1; pwm_lo = 1'b0;
    step();
    chk("R6 stays off", {hs_en, ls_en}, 0);
    por_cycle();

    // R8 same-cycle priority
    ss_done = 1'b1; uv_flag = 1'b1; ov_flag = 1'b1;
    step();
    uv_flag = 1'b0; ov_flag = 1'b0;
    chk("R8 ov beats uv", fault_code, 3);
    por_cycle();

    // R7 over-current filter
    pwm_hi = 1'b1; pwm_lo = 1'b0; oc_flag = 1'b1;
    for (int k = 0; k < 6; k++) begin
      pwm_hi = ~pwm_hi;
      step();
    end
    pwm_hi = 1'b1; oc_flag = 1'b0;
    step();
    chk("R7 oc outside ls ignored", fault_code, 0);
    lo_period(1'b1);
    lo_period(1'b0);
    lo_period(1'b1);
    chk("R7 broken run no trip", fault_code, 0);
    lo_period(1'b1);
    chk("R7 two periods trip", fault_code, 2);
    #0.5;
    chk("R7 oc gates off", {hs_en, ls_en}, 0);
    chk("R9 pg low on oc", pwr_good, 0);
    por_cycle();
    #0.5;
    chk("R1 released after oc", hs_en, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule